// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a free-running timer for a system controller. A counter register advances by one on every clock while the timer is enabled. When it equals a programmable compare value, the block raises an interrupt for exactly one clock. Software reaches the block through three write strobes that share one data bus, one each for the control, compare and counter registers, and it can read all three registers back at any time.

Two control bits choose what happens at a compare hit. In auto-restart mode the counter returns to zero and keeps counting. In one-shot mode the hardware clears its own enable bit, and the counter holds at the compare value. Software can preload the counter. Enabling the timer resumes counting from whatever value the counter holds. If that value is above the compare value, the counter runs on, wraps through zero and then hits. A controller normally instantiates the block twice. Address decoding and prescaling belong to the surrounding logic.

Top module: `cmp_timer`

## Requirements
- R1: Control register bit 0 is the enable bit and bit 1 is the auto-restart bit. A control write stores `wdata[1:0]`, and `ctl_q` reads the stored bits back on the next cycle.
- R2: While enabled, and with no hit and no counter write, `cnt_q` increases by one per clock, wrapping from 2^W-1 to 0.
- R3: A hit is the enable bit set together with `cnt_q == cmp_q`. `irq` is high in the cycle after the hit clock edge and low otherwise. A single hit in one-shot mode gives an `irq` exactly one cycle wide.
- R4: On a hit with auto-restart clear, the enable bit clears and `cnt_q` holds at the compare value.
- R5: On a hit with auto-restart set, `cnt_q` goes to 0 and counting continues. With a compare value of N the hit period is N+1 cycles.
- R6: A counter write loads `wdata` and takes priority over counting. From a start value S and a compare value C, the hit occurs ((C-S) mod 2^W)+1 clocks after the enabling edge, so a start value above the compare value wraps through zero first.
- R7: A compare write takes effect on the next cycle for hit detection, including while the timer runs, and reads back on `cmp_q`.
- R8: While the enable bit is clear and no counter write occurs, `cnt_q` does not change.
- R9: A synchronous reset clears the control, compare and counter registers and `irq`.
- R10: When a control write and a one-shot hit fall in the same cycle, the written control value wins. The interrupt still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| cmp_we | input | 1 | Compare register write strobe |
| cnt_we | input | 1 | Counter register write strobe |
| wdata | input | W | Write data shared by all three strobes |
| ctl_q | output | 2 | Control readback: bit 1 auto-restart, bit 0 enable |
| cmp_q | output | W | Compare value readback |
| cnt_q | output | W | Counter value readback |
| irq | output | 1 | One-cycle interrupt pulse after each hit |

## Verification
The assertions take for granted that each write strobe is a clean, single-cycle level driven away from the clock edge. They do not assume that the strobes are mutually exclusive or that they avoid hit cycles. The properties on counting and holding are qualified by the absence of counter and control writes. The stimulus issues each write on a falling edge and removes it on the next falling edge. It deliberately lines up a control write with a one-shot hit, and it sweeps start and compare values, including start values above the compare value, on an 8-bit instance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W  = 2;
  localparam int EN_BIT = 0;
  localparam int AR_BIT = 1;

  typedef struct packed {
    logic auto_rst;
    logic en;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wbits,
  input  logic             hit,
  output tmr_ctl_t         ctl
);
  // software write has priority over the hardware one-shot clear (R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (we) begin
      ctl.en       <= wbits[EN_BIT];
      ctl.auto_rst <= wbits[AR_BIT];
    end else if (hit && !ctl.auto_rst) begin
      ctl.en <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_we,
  input  logic         cnt_we,
  input  logic [W-1:0] wdata,
  input  logic         en,
  input  logic         auto_rst,
  output logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  assign hit = en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)         cmp <= '0;
    else if (cmp_we) cmp <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (cnt_we) cnt <= wdata;
    else if (hit)    cnt <= auto_rst ? '0 : cnt;
    else if (en)     cnt <= cnt + ONE;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             cmp_we,
  input  logic             cnt_we,
  input  logic [W-1:0]     wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [W-1:0]     cmp_q,
  output logic [W-1:0]     cnt_q,
  output logic             irq
);
  tmr_ctl_t ctl;
  logic     hit;

  tmr_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wbits (wdata[CTL_W-1:0]),
    .hit   (hit),
    .ctl   (ctl)
  );

  tmr_count #(.W(W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .cmp_we   (cmp_we),
    .cnt_we   (cnt_we),
    .wdata    (wdata),
    .en       (ctl.en),
    .auto_rst (ctl.auto_rst),
    .cmp      (cmp_q),
    .cnt      (cnt_q),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end

  assign ctl_q = {ctl.auto_rst, ctl.en};

  // R2: counts up by one per clock when enabled and not at a hit
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[EN_BIT] && cnt_q != cmp_q && !cnt_we) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3: interrupt only follows a hit cycle
  a_r3_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctl_q[EN_BIT] && cnt_q == cmp_q));

  // R4: one-shot hit clears enable
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[EN_BIT] && !ctl_q[AR_BIT] && cnt_q == cmp_q && !ctl_we) |=> !ctl_q[EN_BIT]);

  // R4: one-shot hit holds the counter
  a_r4_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[EN_BIT] && !ctl_q[AR_BIT] && cnt_q == cmp_q && !cnt_we) |=> $stable(cnt_q));

  // R5: auto-restart hit returns the counter to zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[EN_BIT] && ctl_q[AR_BIT] && cnt_q == cmp_q && !cnt_we) |=> (cnt_q == '0));

  // R8: counter frozen while disabled
  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[EN_BIT] && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctl_we = 1'b0, cmp_we = 1'b0, cnt_we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [1:0]   ctl_q;
  logic [W-1:0] cmp_q, cnt_q;
  logic         irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.W(W)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .cmp_we(cmp_we), .cnt_we(cnt_we),
    .wdata(wdata), .ctl_q(ctl_q), .cmp_q(cmp_q), .cnt_q(cnt_q), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // which: 0 control, 1 compare, 2 counter; called at a falling edge
  task automatic wr(int which, int d);
    ctl_we = (which == 0);
    cmp_we = (which == 1);
    cnt_we = (which == 2);
    wdata  = W'(d);
    @(negedge clk);
    ctl_we = 1'b0; cmp_we = 1'b0; cnt_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int starts[4] = '{0, 3, 7, 250};
    int cmps[4]   = '{0, 1, 5, 200};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ctl", ctl_q, 0);
    chk("R9 cmp", cmp_q, 0);
    chk("R9 cnt", cnt_q, 0);
    chk("R9 irq", irq, 0);

    // R1 auto-restart bit alone does not enable counting
    wr(2, 9);
    wr(0, 2);
    chk("R1 ctl readback", ctl_q, 2);
    repeat (3) @(negedge clk);
    chk("R1 no count", cnt_q, 9);

    // R6/R2/R3/R4 sweep over start and compare values in one-shot mode
    foreach (starts[i]) begin
      foreach (cmps[j]) begin
        int k;
        int d;
        d = (cmps[j] - starts[i] + M) % M;
        wr(2, starts[i]);
        wr(1, cmps[j]);
        wr(0, 1);
        k = 0;
        while (k < M + 4) begin
          @(negedge clk);
          k++;
          if (irq) break;
        end
        chk("R6 hit latency", k, d + 1);
        chk("R4 enable cleared", ctl_q, 0);
        chk("R4 counter held", cnt_q, cmps[j]);
        @(negedge clk);
        chk("R3 single pulse", irq, 0);
      end
    end

    // R5 auto-restart period
    begin
      int pulses = 0;
      int dbl = 0;
      bit prev = 0;
      wr(2, 0);
      wr(1, 3);
      wr(0, 3);
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (irq) pulses++;
        if (irq && prev) dbl++;
        prev = irq;
      end
      chk("R5 pulse count", pulses, 10);
      chk("R5 no double pulse", dbl, 0);
      chk("R5 still enabled", ctl_q, 3);
    end

    // R8 disable freezes counter
    begin
      int held;
      wr(0, 0);
      held = cnt_q;
      repeat (5) @(negedge clk);
      chk("R8 frozen", cnt_q, held);
    end

    // R7 compare update while running
    begin
      int k = 0;
      wr(2, 0);
      wr(1, 100);
      wr(0, 1);
      repeat (4) @(negedge clk);
      wr(1, 6);
      chk("R7 cmp readback", cmp_q, 6);
      while (k < 20) begin
        @(negedge clk);
        k++;
        if (irq) break;
      end
      chk("R7 new compare hit", k, 2);
    end

    // R10 control write coinciding with a one-shot hit
    wr(2, 0);
    wr(1, 2);
    wr(0, 1);
    repeat (2) @(negedge clk);
    wr(0, 1);
    chk("R10 software write wins", ctl_q, 1);
    chk("R10 irq still pulses", irq, 1);
    @(negedge clk);
    chk("R10 next hit clears", ctl_q, 0);
    chk("R10 second pulse", irq, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule